// File: doc/BRIEF.md
# Watchdog Timeout Status

This block samples one bit of a free-running time-base count, chosen from a small set of tap positions, and treats every 0-to-1 transition of that bit as a watchdog timeout. It keeps a two-bit status. The arm flag records that one timeout has already passed. The hit flag records a timeout that arrived while the arm flag was already set. The first timeout sets the arm flag. A later timeout with the arm flag set and the hit flag clear sets the hit flag. A timeout that finds both flags set changes nothing.

The watchdog interrupt request is the hit flag gated by two enables: the watchdog interrupt enable and the critical-interrupt enable. Software acknowledges a timeout by writing a clear mask to the status port. Every 1 in the mask clears the matching flag, so the request stays active until the hit flag is cleared that way. The time-base counter, the interrupt vectoring and any further escalation after a timeout that finds both flags set live outside this block.

Top module: `wdog_timeout_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both the arm flag and the hit flag, and `wd_irq` is 0 while both enables are 1.
- R2: A timeout while the arm flag is 0 sets the arm flag and leaves the hit flag at its old value.
- R3: A timeout while the arm flag is 1 and the hit flag is 0 sets the hit flag.
- R4: If the selected time-base bit is first seen high at clock edge k, the hit flag is still at its old value on the outputs after edge k. It shows the updated value after edge k+1.
- R5: `wd_irq` is 1 exactly when the hit flag, `wd_irq_en` and `crit_irq_en` are all 1.
- R6: A status write (`stat_wr_en` high at a clock edge) is a clear mask. Mask bit 0 clears the hit flag and mask bit 1 clears the arm flag. A 0 in a mask bit leaves that flag unchanged.
- R7: Once set, the hit flag stays set, and the request stays active, until a status write clears it.
- R8: When a timeout sets a flag in the same cycle that a status write clears that flag, the flag ends up set.
- R9: `period_sel` values 0, 1, 2 and 3 select time-base bits 17, 21, 25 and 29. Transitions on bits that are not selected have no effect.
- R10: Only a 0-to-1 transition counts as a timeout. A selected bit that is already high when reset ends, stays high, or falls does not change the flags.
- R11: A timeout while both flags are 1 leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_count | input | 32 | Free-running time-base count |
| period_sel | input | 2 | Selects which time-base tap is watched |
| wd_irq_en | input | 1 | Watchdog interrupt enable |
| crit_irq_en | input | 1 | Critical-interrupt enable |
| stat_wr_en | input | 1 | Status clear-mask write strobe |
| stat_wr_mask | input | 2 | Clear mask: bit 0 clears the hit flag, bit 1 clears the arm flag |
| stat_arm | output | 1 | Arm flag |
| stat_hit | output | 1 | Hit flag |
| wd_irq | output | 1 | Watchdog interrupt request |

## Verification
The timeout path is driven in four situations: a rise with both flags clear, a rise with only the arm flag set, a rise with both flags set, and a rise that meets a clear write in the update cycle. These separate the arm step, the hit step, the saturated case and the priority between set and clear. Each period selection is paired with rises on the three taps it must ignore, which exposes a wrong tap or a missing mux. A bit held high through reset release, kept high and then dropped shows that only rising transitions count. The cycle-by-cycle check around a single rise pins the two-edge latency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Bit positions of the clear mask and of the packed status
   localparam int unsigned HIT_BIT = 0;
   localparam int unsigned ARM_BIT = 1;
   localparam int unsigned STAT_W  = 2;

   typedef struct packed {
      logic arm;   // bit 1
      logic hit;   // bit 0
   } wdog_flags_t;

endpackage

// File: rtl/wdog_tap_edge.sv
module wdog_tap_edge #(
   parameter int unsigned           TB_W     = 32,
   parameter int unsigned           SEL_W    = 2,
   parameter int unsigned           POS_W    = 8,
   parameter logic [(1<<SEL_W)*POS_W-1:0] TAP_LIST = {8'd29, 8'd25, 8'd21, 8'd17}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TB_W-1:0]   tb_count,
   input  logic [SEL_W-1:0]  period_sel,
   output logic              rise
);

   localparam int unsigned NTAPS = 1 << SEL_W;

   logic [NTAPS-1:0] tap_vec;
   logic             tap_cur;
   logic             stage_q;
   logic             prev_q;
   logic             unused_tb_bits;

   // One tap wire per selectable position; positions fixed at elaboration
   for (genvar gi = 0; gi < NTAPS; gi++) begin : g_tap
      localparam int unsigned POS = TAP_LIST[gi*POS_W +: POS_W];
      initial begin
         assert (POS < TB_W)
            else $error("tap %0d position %0d outside time base width %0d", gi, POS, TB_W);
      end
      assign tap_vec[gi] = tb_count[POS];
   end

   assign tap_cur        = tap_vec[period_sel];
   assign unused_tb_bits = ^tb_count;

   // Two register stages: capture, then history. Reset preloads both with the
   // live tap so a bit already high at reset release is not a rise.
   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= tap_cur;
         prev_q  <= tap_cur;
      end else begin
         stage_q <= tap_cur;
         prev_q  <= stage_q;
      end
   end

   assign rise = stage_q & ~prev_q;

   // R10: a rise pulse lasts one cycle only
   p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/wdog_status_flags.sv
module wdog_status_flags
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              rise,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_mask,
   output wdog_flags_t       flags
);

   logic clr_hit, clr_arm;
   logic set_hit, set_arm;
   wdog_flags_t flags_n;

   assign clr_hit = wr_en & wr_mask[HIT_BIT];
   assign clr_arm = wr_en & wr_mask[ARM_BIT];
   assign set_arm = rise & ~flags.arm;
   assign set_hit = rise &  flags.arm & ~flags.hit;

   // Set terms are ORed after the clear, so a hardware set outranks a clear
   always_comb begin
      flags_n.arm = set_arm | (flags.arm & ~clr_arm);
      flags_n.hit = set_hit | (flags.hit & ~clr_hit);
   end

   always_ff @(posedge clk) begin
      if (rst) flags <= '0;
      else     flags <= flags_n;
   end

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (flags == '0));

   p_arm_r2: assert property (@(posedge clk) disable iff (rst)
      (rise && !flags.arm && !(wr_en && wr_mask[HIT_BIT])) |=> (flags.arm && $stable(flags.hit)));

   p_hit_r3: assert property (@(posedge clk) disable iff (rst)
      (rise && flags.arm && !flags.hit) |=> flags.hit);

   p_clear_hit_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mask[HIT_BIT] && !(rise && flags.arm && !flags.hit)) |=> !flags.hit);

   p_clear_arm_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mask[ARM_BIT] && !(rise && !flags.arm)) |=> !flags.arm);

   p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (flags.hit && !(wr_en && wr_mask[HIT_BIT])) |=> flags.hit);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (rise && !flags.arm && wr_en && wr_mask[ARM_BIT]) |=> flags.arm);

   p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
      (rise && flags.arm && flags.hit && !wr_en) |=> $stable(flags));

endmodule

// File: rtl/wdog_timeout_status.sv
module wdog_timeout_status
   import wdog_pkg::*;
#(
   parameter int unsigned TB_W  = 32,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned POS_W = 8,
   parameter logic [(1<<SEL_W)*POS_W-1:0] TAP_LIST = {8'd29, 8'd25, 8'd21, 8'd17}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TB_W-1:0]   tb_count,
   input  logic [SEL_W-1:0]  period_sel,
   input  logic              wd_irq_en,
   input  logic              crit_irq_en,
   input  logic              stat_wr_en,
   input  logic [1:0]        stat_wr_mask,
   output logic              stat_arm,
   output logic              stat_hit,
   output logic              wd_irq
);

   logic        rise;
   wdog_flags_t flags;

   wdog_tap_edge #(
      .TB_W     (TB_W),
      .SEL_W    (SEL_W),
      .POS_W    (POS_W),
      .TAP_LIST (TAP_LIST)
   ) u_tap (
      .clk        (clk),
      .rst        (rst),
      .tb_count   (tb_count),
      .period_sel (period_sel),
      .rise       (rise)
   );

   wdog_status_flags u_flags (
      .clk     (clk),
      .rst     (rst),
      .rise    (rise),
      .wr_en   (stat_wr_en),
      .wr_mask (stat_wr_mask),
      .flags   (flags)
   );

   assign stat_arm = flags.arm;
   assign stat_hit = flags.hit;
   assign wd_irq   = flags.hit & wd_irq_en & crit_irq_en;

   // R5: request follows the flag from the status module and both enables
   p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
      wd_irq |-> (flags.hit && wd_irq_en && crit_irq_en));

   // R7: with both enables held, the request cannot drop without a hit clear
   p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (wd_irq && wd_irq_en && crit_irq_en && !(stat_wr_en && stat_wr_mask[0]))
         |=> (stat_hit));

endmodule

// File: tb/wdog_timeout_status_tb_top.sv
module wdog_timeout_status_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] tb_count = '0;
   logic [1:0]  period_sel = 2'd0;
   logic        wd_irq_en = 1'b0;
   logic        crit_irq_en = 1'b0;
   logic        stat_wr_en = 1'b0;
   logic [1:0]  stat_wr_mask = 2'b00;
   logic        stat_arm, stat_hit, wd_irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 4 ns period

   wdog_timeout_status dut_i (
      .clk          (clk),
      .rst          (rst),
      .tb_count     (tb_count),
      .period_sel   (period_sel),
      .wd_irq_en    (wd_irq_en),
      .crit_irq_en  (crit_irq_en),
      .stat_wr_en   (stat_wr_en),
      .stat_wr_mask (stat_wr_mask),
      .stat_arm     (stat_arm),
      .stat_hit     (stat_hit),
      .wd_irq       (wd_irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_flags(input string req, input bit e_arm, input bit e_hit);
      chk(stat_arm == e_arm, {req, " arm"}, int'(stat_arm), int'(e_arm));
      chk(stat_hit == e_hit, {req, " hit"}, int'(stat_hit), int'(e_hit));
   endtask

   // Raise one time-base bit, hold it across both pipeline edges, drop it
   task automatic do_rise(input int pos);
      @(negedge clk) tb_count[pos] = 1'b1;
      repeat (2) @(negedge clk);
      tb_count[pos] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_write(input logic [1:0] mask);
      @(negedge clk);
      stat_wr_en   = 1'b1;
      stat_wr_mask = mask;
      @(negedge clk);
      stat_wr_en   = 1'b0;
      stat_wr_mask = 2'b00;
   endtask

   task automatic t_reset;
      wd_irq_en   = 1'b1;
      crit_irq_en = 1'b1;
      tb_count[17] = 1'b1;           // high through reset release
      repeat (3) @(negedge clk);
      chk_flags("R1", 1'b0, 1'b0);
      chk(wd_irq == 1'b0, "R1 irq", int'(wd_irq), 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk_flags("R10 high at release", 1'b0, 1'b0);
      tb_count[17] = 1'b0;           // falling edge
      repeat (3) @(negedge clk);
      chk_flags("R10 fall", 1'b0, 1'b0);
      wd_irq_en   = 1'b0;
   endtask

   task automatic t_arm;
      do_rise(17);
      chk_flags("R2", 1'b1, 1'b0);
   endtask

   task automatic t_latency;
      @(negedge clk) tb_count[17] = 1'b1;
      @(negedge clk);
      chk(stat_hit == 1'b0, "R4 after first edge", int'(stat_hit), 0);
      @(negedge clk);
      chk(stat_hit == 1'b1, "R4 after second edge", int'(stat_hit), 1);
      chk_flags("R3", 1'b1, 1'b1);
      tb_count[17] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_irq;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         wd_irq_en   = k[0];
         crit_irq_en = k[1];
         #1;
         chk(wd_irq == (k == 3), "R5", int'(wd_irq), int'(k == 3));
      end
   endtask

   task automatic t_sticky;
      repeat (12) @(negedge clk);
      chk(stat_hit == 1'b1, "R7 hit", int'(stat_hit), 1);
      chk(wd_irq == 1'b1, "R7 irq", int'(wd_irq), 1);
   endtask

   task automatic t_saturate;
      do_rise(17);
      chk_flags("R11", 1'b1, 1'b1);
   endtask

   task automatic t_clear;
      do_write(2'b00);
      chk_flags("R6 zero mask", 1'b1, 1'b1);
      do_write(2'b01);
      chk_flags("R6 hit mask", 1'b1, 1'b0);
      chk(wd_irq == 1'b0, "R6 irq", int'(wd_irq), 0);
      do_write(2'b10);
      chk_flags("R6 arm mask", 1'b0, 1'b0);
   endtask

   task automatic t_set_wins;
      do_rise(17);                   // arm = 1
      @(negedge clk) tb_count[17] = 1'b1;
      @(negedge clk);                // after capture edge; update at next edge
      stat_wr_en   = 1'b1;
      stat_wr_mask = 2'b11;
      @(negedge clk);
      stat_wr_en   = 1'b0;
      stat_wr_mask = 2'b00;
      chk_flags("R8", 1'b0, 1'b1);
      tb_count[17] = 1'b0;
      repeat (2) @(negedge clk);
      do_write(2'b11);
   endtask

   task automatic t_tap_select;
      int taps [4] = '{17, 21, 25, 29};
      for (int s = 0; s < 4; s++) begin
         @(negedge clk) period_sel = 2'(s);
         repeat (2) @(negedge clk);
         for (int j = 0; j < 4; j++) begin
            if (j != s) do_rise(taps[j]);
         end
         chk(stat_arm == 1'b0, $sformatf("R9 sel %0d other taps", s), int'(stat_arm), 0);
         do_rise(taps[s]);
         chk(stat_arm == 1'b1, $sformatf("R9 sel %0d own tap", s), int'(stat_arm), 1);
         do_write(2'b11);
      end
      @(negedge clk) period_sel = 2'd0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_level;
      @(negedge clk) tb_count[17] = 1'b1;
      repeat (10) @(negedge clk);
      chk_flags("R10 held high", 1'b1, 1'b0);
      do_write(2'b10);
      repeat (3) @(negedge clk);
      chk_flags("R10 high after clear", 1'b0, 1'b0);
      tb_count[17] = 1'b0;
      repeat (3) @(negedge clk);
      chk_flags("R10 fall after clear", 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_arm();
      t_latency();
      t_irq();
      t_sticky();
      t_saturate();
      t_clear();
      t_set_wins();
      t_tap_select();
      t_level();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule